// File: doc/BRIEF.md
# Switch Debouncer with Separated Control and Countdown Datapath

This block cleans up a single switch input that has already been brought into the clock domain. It reports a filtered level that changes only after the raw input has held its new value across a full settling window. It also produces a single-cycle pulse when a low-to-high change is confirmed. The window length, in clock cycles, is a parameter.

Inside, a four-state controller tracks four conditions: settled low, candidate rise, settled high and candidate fall. It never touches the count register directly. It only issues a load strobe and a decrement strobe to a separate countdown datapath. The datapath returns one flag, which says whether the count it is about to register is zero. The controller decides each exit from that next-count flag instead of the stored count, so a wait state costs no extra cycle. The interface is plain level pins. There is no data stream, so there is no valid/ready handshake.

Top module: `sw_debounce`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `level` = 0 and `tick` = 0, whatever the value of `sw`.
- R2: With `level` low, `level` goes high right after the rising edge that samples `sw` = 1 for the (WINDOW+1)-th consecutive time. The first of those samples loads the counter, and each of the next WINDOW samples decrements it.
- R3: `tick` is 1 for exactly the cycle in which `level` is still 0 and the sampled `sw` is the (WINDOW+1)-th consecutive 1. In the next cycle `level` is 1. `tick` is 0 in every other cycle.
- R4: With `level` high, `level` goes low right after the edge that samples `sw` = 0 for the (WINDOW+1)-th consecutive time. No `tick` is produced for this change.
- R5: A run of differing samples shorter than WINDOW+1 leaves `level` unchanged. The next differing run counts from the beginning again.
- R6: While `sw` equals `level`, `level` holds and `tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 1 | Raw switch value, already synchronous to `clk` |
| level | output | 1 | Debounced switch level |
| tick | output | 1 | One-cycle pulse on a confirmed low-to-high change |

## Verification
The most revealing case is a pulse exactly WINDOW+1 samples long next to one that is a single sample shorter. A design that compares the stored count instead of the next count flips one cycle late and fails the first. A design with an off-by-one reload flips on the short pulse. The bench also sends rapid bounces that return to the settled value partway through a wait. A controller that kept a stale count instead of reloading would then confirm too early on the following run. A tick that is checked in a fixed cycle catches a registered or stretched pulse, and falling edges are watched to make sure they never produce a tick.

// File: rtl/sw_debounce_pkg.sv
package sw_debounce_pkg;

  // Controller states. Level is high in the two upper encodings.
  typedef enum logic [1:0] {
    DB_LOW   = 2'b00,  // settled low
    DB_RISE  = 2'b01,  // candidate rise, counting down
    DB_HIGH  = 2'b10,  // settled high
    DB_FALL  = 2'b11   // candidate fall, counting down
  } db_state_e;

  function automatic int unsigned cnt_width(input int unsigned window);
    return (window < 1) ? 1 : $clog2(window + 1);
  endfunction

endpackage

// File: rtl/sw_debounce_count.sv
module sw_debounce_count #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic nxt_zero
);
  localparam int unsigned CW = sw_debounce_pkg::cnt_width(WINDOW);
  localparam logic [CW-1:0] RELOAD = CW'(WINDOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  // Next-count: holds by default on every path, so no latch.
  always_comb begin
    cnt_nxt = cnt_q;
    if (load) begin
      cnt_nxt = RELOAD;
    end else if (dec) begin
      cnt_nxt = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  assign nxt_zero = (cnt_nxt == '0);

endmodule

// File: rtl/sw_debounce_ctrl.sv
module sw_debounce_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sw,
  input  logic nxt_zero,
  output logic load,
  output logic dec,
  output logic level,
  output logic tick
);
  import sw_debounce_pkg::*;

  db_state_e st_q;
  db_state_e st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    dec  = 1'b0;
    tick = 1'b0;
    unique case (st_q)
      DB_LOW: begin
        if (sw) begin
          load = 1'b1;
          st_d = DB_RISE;
        end
      end
      DB_RISE: begin
        if (!sw) begin
          st_d = DB_LOW;
        end else begin
          dec = 1'b1;
          if (nxt_zero) begin
            tick = 1'b1;
            st_d = DB_HIGH;
          end
        end
      end
      DB_HIGH: begin
        if (!sw) begin
          load = 1'b1;
          st_d = DB_FALL;
        end
      end
      DB_FALL: begin
        if (sw) begin
          st_d = DB_HIGH;
        end else begin
          dec = 1'b1;
          if (nxt_zero) begin
            st_d = DB_LOW;
          end
        end
      end
      default: st_d = DB_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= DB_LOW;
    end else begin
      st_q <= st_d;
    end
  end

  assign level = (st_q == DB_HIGH) || (st_q == DB_FALL);

endmodule

// File: rtl/sw_debounce.sv
module sw_debounce #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sw,
  output logic level,
  output logic tick
);
  logic load;
  logic dec;
  logic nxt_zero;

  sw_debounce_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sw       (sw),
    .nxt_zero (nxt_zero),
    .load     (load),
    .dec      (dec),
    .level    (level),
    .tick     (tick)
  );

  sw_debounce_count #(.WINDOW(WINDOW)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .dec      (dec),
    .nxt_zero (nxt_zero)
  );

endmodule

// File: rtl/sw_debounce_chk.sv
module sw_debounce_chk (
  input logic clk,
  input logic rst,
  input logic sw,
  input logic level,
  input logic tick
);

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!level && !tick));

  // R3
  tick_while_low_chk: assert property (@(posedge clk) disable iff (rst) tick |-> !level);

  // R3
  tick_then_high_chk: assert property (@(posedge clk) disable iff (rst) tick |=> level);

  // R2
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (rst) $rose(level) |-> $past(tick));

  // R4
  fall_needs_low_sw_chk: assert property (@(posedge clk) disable iff (rst) $fell(level) |-> $past(!sw));

  // R6
  agree_holds_chk: assert property (@(posedge clk) disable iff (rst) (sw == level) |=> $stable(level));

endmodule

bind sw_debounce sw_debounce_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .sw    (sw),
  .level (level),
  .tick  (tick)
);

// File: tb/tb_sw_debounce.sv
module tb_sw_debounce;
  localparam int unsigned WIN = 5;
  localparam time PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw  = 1'b0;
  logic level;
  logic tick;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_lvl = 1'b0;
  int m_run = 0;
  bit m_flipped = 1'b0;

  always #(PER/2) clk = ~clk;

  sw_debounce #(.WINDOW(WIN)) dut (
    .clk(clk), .rst(rst), .sw(sw), .level(level), .tick(tick)
  );

  function automatic int next_run(bit lvl, int run, bit s);
    return (s != lvl) ? run + 1 : 0;
  endfunction

  function automatic bit exp_tick(bit lvl, int run_now, bit s);
    return !lvl && s && (run_now == WIN + 1);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // drive one sample at negedge, check outputs mid-cycle, advance model
  task automatic step(bit s);
    int r;
    bit et;
    string rq;
    @(negedge clk);
    sw = s;
    #1;
    r  = next_run(m_lvl, m_run, s);
    et = exp_tick(m_lvl, r, s);
    if (m_flipped) rq = m_lvl ? "R2" : "R4";
    else if (m_run > 0) rq = "R5";
    else rq = "R6";
    check(rq, level, m_lvl, "level");
    if (et) rq = "R3";
    else if (m_lvl && r == WIN + 1) rq = "R4";
    check(rq, tick, et, "tick");
    if (r == WIN + 1) begin
      m_lvl = s;
      m_run = 0;
      m_flipped = 1'b1;
    end else begin
      m_run = r;
      m_flipped = 1'b0;
    end
  endtask

  task automatic hold(bit s, int n);
    for (int i = 0; i < n; i++) step(s);
  endtask

  initial begin : watchdog
    #(PER * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    // R1: reset with switch high
    sw = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", level, 1'b0, "level in reset");
    check("R1", tick, 1'b0, "tick in reset");
    @(negedge clk);
    rst = 1'b0;
    sw  = 1'b0;
    #1;
    check("R1", level, 1'b0, "level after reset");
    check("R1", tick, 1'b0, "tick after reset");

    // R6 quiet low
    hold(1'b0, 4);
    // R5 pulse one short of the window, then exact window (R2, R3)
    hold(1'b1, WIN);
    hold(1'b0, 2);
    hold(1'b1, WIN + 1);
    hold(1'b1, 3);
    // R4 falling: short then exact
    hold(1'b0, WIN);
    hold(1'b1, 1);
    hold(1'b0, WIN + 1);
    hold(1'b0, 2);
    // R5 bounce train restarting count
    for (int i = 0; i < 6; i++) begin
      hold(1'b1, 1 + (i % 3));
      hold(1'b0, 1);
    end
    hold(1'b1, WIN + 3);
    // mid-run reset (R1)
    hold(1'b0, 2);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1", level, 1'b0, "level after mid reset");
    check("R1", tick, 1'b0, "tick after mid reset");
    rst = 1'b0;
    m_lvl = 1'b0;
    m_run = 0;
    m_flipped = 1'b0;
    sw = 1'b0;

    // constrained random segments
    for (int seg = 0; seg < 400; seg++) begin
      bit v;
      int len;
      v   = ((seg % 2) == 0);
      len = $urandom_range(1, WIN + 3);
      hold(v, len);
    end
    hold(1'b0, WIN + 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule